// File: doc/BRIEF.md
# Dual-Channel Single-Slope PWM Timer

This block is an up-counting timer that drives two PWM outputs from one shared period. The counter runs from zero up to a programmable TOP value and then restarts at zero. Each channel has its own compare value and a 2-bit output mode. In the default fast PWM mode each output is set or cleared explicitly at the cycle boundary and at its compare match. Duty changes written while the timer runs are held in a buffer and take effect only at the boundary. That means a duty update can never invert the waveform.

A second counting mode clears the counter at TOP and applies only the per-channel match action. In that mode compare writes take effect at once. A per-channel force strobe applies a channel's match action immediately. Two event flags record the period match and the counter overflow. Software clears a flag by writing a one to its bit. All of this is reached through a single synchronous register port.

For example, with a 20 MHz clock a TOP of 799 gives an 800-clock period, which is 25 kHz.

Register map (address: content):
- 0, control: bit 0 run, bit 1 clear-at-TOP mode, bits [3:2] ch0 output mode, bits [5:4] ch1 output mode, bits 8/9 force ch0/ch1. The force bits are write-only strobes and read as 0.
- 1: TOP.
- 2: counter.
- 3, flags: bit 0 period flag, bit 1 overflow flag. Writing a one to a bit clears it.
- 4 and 5: compare ch0 and ch1. A read returns the buffered value.

Output mode encoding: 0 disconnected, 1 toggle on match, 2 clear on match, 3 set on match.

Top module: `pwm2_timer`

## Requirements
- R1: After reset, all of the following read 0: control, TOP, counter, flags and both compares. Both outputs are low.
- R2: In fast PWM mode (control bit 1 = 0) while running:
  - The counter counts up by one each clock.
  - When the counter equals TOP it returns to 0.
  - At that wrap both flag bits 0 and 1 are set.
- R3: In fast PWM mode the output level over each period of TOP+1 clocks depends on the mode:
  - Mode 2: the output is high for compare+1 clocks. It is set at the wrap and cleared after the match.
  - Mode 3: the output is high for TOP-compare clocks.
- R4: In fast PWM mode, a compare write made while running behaves as follows:
  - It is read back at once.
  - It changes the active compare value only at the next wrap. The current period finishes with the old value.
  - A value written below the current count gives no inversion: the output is cleared at the new value in the next period.
- R5: In clear-at-TOP mode (control bit 1 = 1):
  - The counter clears at TOP and flag bit 0 is set.
  - Flag bit 1 is set only when the counter rolls over from all ones, not at TOP.
  - Compare writes take effect immediately. This also applies whenever the timer is stopped.
- R6: In mode 1 the output inverts on each match. In mode 0 the output is held low.
- R7: A compare value above TOP never matches. In fast PWM mode 2 the output then stays high for the whole period.
- R8: A force bit changes the output as follows:
  - It applies that channel's match action on the next clock, even when the timer is stopped.
  - It has no effect on the output level held for mode 0.
- R9: A counter write blocks compare matches for the following clock, when the counter holds the written value.
- R10: Writing ones to the flags register clears the corresponding flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| pwm_o | output | 2 | PWM outputs, bit k is channel k |

## Verification
The assertions check the following on every cycle:
- The counting rule: increment, or wrap to zero at TOP.
- That the active compare value stays still between wraps in fast PWM mode.
- That the outputs stay still while the timer is stopped and no force is pending.
- That the overflow flag is not raised in clear-at-TOP mode short of a rollover.

Only the bench scenarios can show the properties that depend on whole waveforms and on sequences of register writes:
- The measured high time per period for each mode.
- The exact period in which a buffered compare lands.
- That a below-count write causes no inversion.
- The match blocking after a counter write.
- The force and flag-clearing behaviour.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  typedef enum logic [1:0] {
    OM_OFF = 2'd0,
    OM_TGL = 2'd1,
    OM_CLR = 2'd2,
    OM_SET = 2'd3
  } out_mode_e;

  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_TOP  = 1;
  localparam int unsigned A_CNT  = 2;
  localparam int unsigned A_FLAG = 3;
  localparam int unsigned A_CMP0 = 4;

  localparam int unsigned C_RUN    = 0;
  localparam int unsigned C_CTC    = 1;
  localparam int unsigned C_MODE0  = 2;
  localparam int unsigned C_FORCE0 = 8;

  function automatic logic match_act(input out_mode_e m, input logic cur);
    case (m)
      OM_TGL:  return ~cur;
      OM_CLR:  return 1'b0;
      OM_SET:  return 1'b1;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2,   // up to 3 with this control layout
  parameter int unsigned ADDR_W = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CNT_W-1:0]         wdata_i,
  output logic [CNT_W-1:0]         rdata_o,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [NUM_CH*CNT_W-1:0]  cmp_buf_i,
  input  logic                     top_evt_i,
  input  logic                     ovf_evt_i,
  output logic                     run_o,
  output logic                     ctc_o,
  output logic [2*NUM_CH-1:0]      mode_o,
  output logic [NUM_CH-1:0]        force_o,
  output logic [CNT_W-1:0]         top_o,
  output logic [1:0]               flags_o,
  output logic                     cnt_we_o,
  output logic [NUM_CH-1:0]        cmp_we_o
);
  localparam int unsigned CTRL_W = C_MODE0 + 2 * NUM_CH;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  top_q;
  logic [1:0]        flag_q;
  logic              wr_ctrl, wr_top, wr_flag;

  assign wr_ctrl  = we_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_top   = we_i && (addr_i == ADDR_W'(A_TOP));
  assign wr_flag  = we_i && (addr_i == ADDR_W'(A_FLAG));
  assign cnt_we_o = we_i && (addr_i == ADDR_W'(A_CNT));

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp_we
    assign cmp_we_o[k] = we_i && (addr_i == ADDR_W'(A_CMP0 + k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      top_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_top)  top_q  <= wdata_i;
      // set wins over a simultaneous clear
      flag_q[0] <= top_evt_i | (flag_q[0] & ~(wr_flag & wdata_i[0]));
      flag_q[1] <= ovf_evt_i | (flag_q[1] & ~(wr_flag & wdata_i[1]));
    end
  end

  assign run_o   = ctrl_q[C_RUN];
  assign ctc_o   = ctrl_q[C_CTC];
  assign mode_o  = ctrl_q[C_MODE0 +: 2*NUM_CH];
  assign force_o = wr_ctrl ? wdata_i[C_FORCE0 +: NUM_CH] : '0;
  assign top_o   = top_q;
  assign flags_o = flag_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o[CTRL_W-1:0] = ctrl_q;
    if (addr_i == ADDR_W'(A_TOP))  rdata_o = top_q;
    if (addr_i == ADDR_W'(A_CNT))  rdata_o = cnt_i;
    if (addr_i == ADDR_W'(A_FLAG)) rdata_o[1:0] = flag_q;
    for (int k = 0; k < NUM_CH; k++) begin
      if (addr_i == ADDR_W'(A_CMP0 + k)) rdata_o = cmp_buf_i[k*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/pwm2_counter.sv
module pwm2_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] top_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             roll_o,
  output logic             blk_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             blk_q;

  assign wrap_o = run_i && !cnt_we_i && (cnt_q == top_i);
  assign roll_o = run_i && !cnt_we_i && (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      blk_q <= cnt_we_i;
      if (cnt_we_i)    cnt_q <= wdata_i;
      else if (wrap_o) cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign blk_o = blk_q;
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             ctc_i,
  input  out_mode_e        mode_i,
  input  logic             wrap_i,
  input  logic             blk_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             force_i,
  output logic [CNT_W-1:0] cmp_buf_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             pin_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] buf_q, act_q;
  logic             pin_q, pin_d, direct, match;

  assign direct = !run_i || ctc_i;
  assign match  = run_i && !blk_i && (cnt_i == act_q);

  always_comb begin
    pin_d = pin_q;
    if (match) pin_d = match_act(mode_i, pin_q);
    // boundary action overrides a match in the same clock
    if (wrap_i && !ctc_i) begin
      if (mode_i == OM_CLR)      pin_d = 1'b1;
      else if (mode_i == OM_SET) pin_d = 1'b0;
    end
    if (force_i) pin_d = match_act(mode_i, pin_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
      if (cmp_we_i) buf_q <= wdata_i;
      if (cmp_we_i && direct)    act_q <= wdata_i;
      else if (wrap_i && !ctc_i) act_q <= buf_q;
    end
  end

  assign cmp_buf_o = buf_q;
  assign cmp_act_o = act_q;
  assign pin_o     = pin_q;
  assign pwm_o     = (mode_i == OM_OFF) ? 1'b0 : pin_q;
endmodule

// File: rtl/pwm2_timer.sv
module pwm2_timer
  import pwm2_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic                    run, ctc, cnt_we, wrap, roll, blk;
  logic [CNT_W-1:0]        cnt, top;
  logic [2*NUM_CH-1:0]     mode_flat;
  logic [NUM_CH-1:0]       force_v, cmp_we, pin_v;
  logic [NUM_CH*CNT_W-1:0] cmp_buf_flat, cmp_act_flat;
  logic [1:0]              flags;
  logic                    ovf_evt;

  assign ovf_evt = ctc ? roll : wrap;

  pwm2_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .cmp_buf_i(cmp_buf_flat), .top_evt_i(wrap), .ovf_evt_i(ovf_evt),
    .run_o(run), .ctc_o(ctc), .mode_o(mode_flat), .force_o(force_v),
    .top_o(top), .flags_o(flags), .cnt_we_o(cnt_we), .cmp_we_o(cmp_we)
  );

  pwm2_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .top_i(top), .cnt_we_i(cnt_we), .wdata_i,
    .cnt_o(cnt), .wrap_o(wrap), .roll_o(roll), .blk_o(blk)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm2_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i, .rst_ni, .run_i(run), .ctc_i(ctc),
      .mode_i(out_mode_e'(mode_flat[2*k +: 2])),
      .wrap_i(wrap), .blk_i(blk), .cnt_i(cnt),
      .cmp_we_i(cmp_we[k]), .wdata_i, .force_i(force_v[k]),
      .cmp_buf_o(cmp_buf_flat[k*CNT_W +: CNT_W]),
      .cmp_act_o(cmp_act_flat[k*CNT_W +: CNT_W]),
      .pin_o(pin_v[k]), .pwm_o(pwm_o[k])
    );
  end
endmodule

// File: rtl/pwm2_timer_chk.sv
module pwm2_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_CH = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    run_i,
  input logic                    ctc_i,
  input logic                    cnt_we_i,
  input logic                    wrap_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic [CNT_W-1:0]        top_i,
  input logic [NUM_CH-1:0]       force_i,
  input logic [NUM_CH-1:0]       pin_i,
  input logic [NUM_CH*CNT_W-1:0] cmp_act_i,
  input logic [1:0]              flags_i
);
  a_r2_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !cnt_we_i && (cnt_i == top_i) |=> cnt_i == '0);

  a_r2_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !cnt_we_i && (cnt_i != top_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  a_r8_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && (force_i == '0) |=> $stable(pin_i));

  a_r5_ctc_no_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctc_i && (cnt_i != '1) && !flags_i[1] |=> !flags_i[1]);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_a
    a_r4_cmp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i && !ctc_i && !wrap_i |=> $stable(cmp_act_i[k*CNT_W +: CNT_W]));
  end
endmodule

bind pwm2_timer pwm2_timer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .ctc_i(ctc), .cnt_we_i(cnt_we),
  .wrap_i(wrap), .cnt_i(cnt), .top_i(top), .force_i(force_v), .pin_i(pin_v),
  .cmp_act_i(cmp_act_flat), .flags_i(flags)
);

// File: tb/pwm2_timer_tb.sv
module pwm2_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic [1:0]  pwm;
  int vec = 0, err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwm2_timer u_dut (.clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
                    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm));

  task automatic chk(string req, int act, int exp);
    vec++;
    if (act !== exp) begin
      err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    addr = 3'(a); wdata = 16'(d); we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    addr = 3'(a);
    #1 v = int'(rdata);
  endtask

  task automatic wait_cnt(int v);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      addr = 3'd2;
      #1;
      if (int'(rdata) == v) break;
    end
  endtask

  task automatic count_hi(output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #1;
      h0 += int'(pwm[0]);
      h1 += int'(pwm[1]);
    end
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk("R1 reg", v, 0);
    end
    chk("R1 pwm", int'(pwm), 0);
  endtask

  task automatic t_pwm_basic();
    int h0, h1, v;
    wr(1, 9); wr(4, 3); wr(5, 7);
    wr(0, 16'h0039);
    repeat (25) @(negedge clk);
    count_hi(h0, h1);
    chk("R3 noninv high", h0, 4);
    chk("R3 inv high", h1, 2);
    wait_cnt(9);
    @(negedge clk); addr = 3'd2; #1;
    chk("R2 wrap to zero", int'(rdata), 0);
    @(negedge clk); #1;
    chk("R2 count up", int'(rdata), 1);
    rd(3, v);
    chk("R2 flags", v, 3);
  endtask

  task automatic t_buffer();
    int v;
    wait_cnt(1);
    wr(4, 8);
    rd(4, v);
    chk("R4 readback", v, 8);
    wait_cnt(6);
    chk("R4 old value this period", int'(pwm[0]), 0);
    wait_cnt(0);
    wait_cnt(6);
    chk("R4 new value next period", int'(pwm[0]), 1);
    wr(4, 2);
    wait_cnt(8);
    chk("R4 below count no early clear", int'(pwm[0]), 1);
    wait_cnt(4);
    chk("R4 new low value applied", int'(pwm[0]), 0);
    wait_cnt(1);
    chk("R4 no inversion", int'(pwm[0]), 1);
  endtask

  task automatic t_gt_top();
    int h0, h1;
    wr(0, 16'h0038);
    wr(4, 20);
    wr(0, 16'h0039);
    repeat (25) @(negedge clk);
    count_hi(h0, h1);
    chk("R7 cmp above top stays high", h0, 10);
  endtask

  task automatic t_flags_clear();
    int v;
    wr(0, 16'h0000);
    wr(3, 3);
    rd(3, v);
    chk("R10 flags cleared", v, 0);
  endtask

  task automatic t_ctc();
    int h0, h1, v;
    wr(1, 4); wr(2, 0); wr(4, 2); wr(3, 3);
    wr(0, 16'h0007);  // run, ctc, ch0 toggle
    repeat (20) @(negedge clk);
    count_hi(h0, h1);
    chk("R6 toggle half duty", h0, 5);
    chk("R6 disconnected low", h1, 0);
    rd(3, v);
    chk("R5 top flag only", v, 1);
    wr(4, 3);
    wait_cnt(2);
    v = int'(pwm[0]);
    @(negedge clk); #1;
    chk("R5 direct compare write no match at old", int'(pwm[0]), v);
    @(negedge clk); #1;
    chk("R5 direct compare write match at new", int'(pwm[0]), 1 - v);
    wr(0, 16'h0002);
    wr(1, 5); wr(2, 16'hFFFD); wr(3, 3);
    wr(0, 16'h0003);
    repeat (4) @(negedge clk);
    rd(3, v);
    chk("R5 rollover sets overflow", v, 2);
    repeat (10) @(negedge clk);
    rd(3, v);
    chk("R5 top flag later", v, 3);
  endtask

  task automatic t_cnt_block();
    int p;
    wr(0, 16'h0002);
    wr(1, 1000); wr(4, 50); wr(2, 0);
    wr(0, 16'h0007);
    @(negedge clk); #1;
    p = int'(pwm[0]);
    wr(2, 50);
    repeat (5) @(negedge clk);
    #1;
    chk("R9 match blocked after counter write", int'(pwm[0]), p);
    wr(2, 49);
    repeat (5) @(negedge clk);
    #1;
    chk("R9 match one clock later fires", int'(pwm[0]), 1 - p);
  endtask

  task automatic t_force();
    wr(0, 16'h000C); wr(0, 16'h010C);
    chk("R8 force set", int'(pwm[0]), 1);
    wr(0, 16'h0008); wr(0, 16'h0108);
    chk("R8 force clear", int'(pwm[0]), 0);
    wr(0, 16'h0004); wr(0, 16'h0104);
    chk("R8 force toggle", int'(pwm[0]), 1);
    wr(0, 16'h0000); wr(0, 16'h0100);
    chk("R6 disconnected output low", int'(pwm[0]), 0);
    wr(0, 16'h0004);
    chk("R8 force ignored when disconnected", int'(pwm[0]), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pwm_basic();
    t_buffer();
    t_gt_top();
    t_flags_clear();
    t_ctc();
    t_cnt_block();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      vec++; err++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vec, err);
      $finish;
    end
  end
endmodule